// File: doc/BRIEF.md
# Graphics Engine Interrupt Controller

This block gathers the three interrupt causes raised by a tile-based graphics engine and presents them to a processor through a small register window. Two of the causes are one-shot events: the binning stage finished flushing its final tile list, and the render stage finished a frame. The third is a level condition: the binner has no overflow memory left to spill into. Pending causes are held in a status register that software acknowledges by writing ones. An interrupt line is raised whenever a pending cause is also enabled.

The enable mask has no direct write port. Software turns causes on through an enable-set register and off through an enable-clear register, and reading either address returns the same mask. This lets independent code paths change single bits without a read-modify-write race. The overflow condition starts active out of reset, because no spill pool exists yet. It is re-armed whenever the binner signals that its pool is exhausted. Software retires the condition by programming a fresh pool: the base first, then the size. Only after that does an acknowledge of the status bit take effect.

Top module: `irqc_top`

## Requirements
- R1: While reset is held, the status register, the enable mask, the pool base, the pool size and the `irq` output all read as zero.
- R2: Status bit positions are: bit 0 for binning flush done, bit 1 for render frame done, bit 2 for out of memory. Bits 31..3 read as zero. Writing a 1 to a bit at offset 0x0 clears it, and 0 bits leave it unchanged. A cleared event bit stays clear until its next input pulse.
- R3: If an event pulse and a write-1 clear of the same bit fall in the same cycle, the bit is set afterwards.
- R4: Writing a 1 to a bit at offset 0x4 (enable-set) enables that cause. Bits written as 0 leave the mask unchanged.
- R5: Writing a 1 to a bit at offset 0x8 (enable-clear) disables that cause. Bits written as 0 leave the mask unchanged.
- R6: Reading offset 0x4 or offset 0x8 returns the current enable mask in bits 2..0.
- R7: The out-of-memory condition is active from reset and is set again by a `pool_empty` pulse. While it is active, status bit 2 is set on every clock and a write-1 clear does not remove it.
- R8: Offset 0xC holds the pool base and offset 0x10 holds the pool size. Both are read/write and 32 bits wide. A write to offset 0x10 ends the out-of-memory condition, so the next clear of status bit 2 succeeds. A `pool_empty` pulse in the same cycle as that write keeps the condition active.
- R9: `irq` equals the OR over bits of (status AND enable) as they stood one clock earlier.
- R10: A read of any address other than 0x0, 0x4, 0x8, 0xC or 0x10, including a misaligned one, returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; released synchronously inside |
| wr_en | input | 1 | Single-cycle register write strobe |
| rd_en | input | 1 | Read strobe; `rdata` is valid in the same cycle |
| addr | input | ADDR_W (5) | Byte address of the register |
| wdata | input | DATA_W (32) | Write data |
| rdata | output | DATA_W (32) | Read data; zero when `rd_en` is low |
| flush_done | input | 1 | One-cycle pulse: binning flush finished |
| render_done | input | 1 | One-cycle pulse: frame render finished |
| pool_empty | input | 1 | One-cycle pulse: binner exhausted its overflow pool |
| irq | output | 1 | Registered interrupt request |

## Verification
The hardest states to reach are the ones where a cause and its acknowledge meet. These are an event pulse landing in the very cycle its status bit is cleared, and a `pool_empty` pulse landing in the very cycle the pool size is written. Directed steps drive both strobes on the same clock edge. They then read status two cycles later, when the level bit would already be gone if the order were wrong. A long randomized phase follows, mixing writes to every address with pulses on all three inputs. A behavioural model tracks status, mask, pool registers and the overflow condition, and it is compared with `irq` and with every read on every clock.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam int N_SRC      = 3;
  localparam int SRC_FLUSH  = 0;
  localparam int SRC_RENDER = 1;
  localparam int SRC_OOM    = 2;

  localparam logic [7:0] OFS_STAT   = 8'h00;
  localparam logic [7:0] OFS_EN_SET = 8'h04;
  localparam logic [7:0] OFS_EN_CLR = 8'h08;
  localparam logic [7:0] OFS_BASE   = 8'h0C;
  localparam logic [7:0] OFS_SIZE   = 8'h10;
endpackage

// File: rtl/irqc_rstsync.sv
module irqc_rstsync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_d;

  always_comb sh_d = {sh_q[STAGES-2:0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  assign rst_sync_n = sh_q[STAGES-1];
endmodule

// File: rtl/irqc_regif.sv
module irqc_regif
  import irqc_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 5
) (
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [N_SRC-1:0]  stat,
  input  logic [N_SRC-1:0]  en,
  input  logic [DATA_W-1:0] base,
  input  logic [DATA_W-1:0] size,
  output logic [N_SRC-1:0]  stat_clr,
  output logic [N_SRC-1:0]  en_set,
  output logic [N_SRC-1:0]  en_clr,
  output logic              base_we,
  output logic              size_we,
  output logic [DATA_W-1:0] rdata
);
  logic hit_stat, hit_set, hit_clr, hit_base, hit_size;

  always_comb begin
    hit_stat = (addr == ADDR_W'(OFS_STAT));
    hit_set  = (addr == ADDR_W'(OFS_EN_SET));
    hit_clr  = (addr == ADDR_W'(OFS_EN_CLR));
    hit_base = (addr == ADDR_W'(OFS_BASE));
    hit_size = (addr == ADDR_W'(OFS_SIZE));
  end

  always_comb begin
    stat_clr = (wr_en && hit_stat) ? wdata[N_SRC-1:0] : '0;
    en_set   = (wr_en && hit_set)  ? wdata[N_SRC-1:0] : '0;
    en_clr   = (wr_en && hit_clr)  ? wdata[N_SRC-1:0] : '0;
    base_we  = wr_en && hit_base;
    size_we  = wr_en && hit_size;
  end

  always_comb begin
    rdata = '0;
    if (rd_en) begin
      if (hit_stat)              rdata[N_SRC-1:0] = stat;
      else if (hit_set || hit_clr) rdata[N_SRC-1:0] = en;
      else if (hit_base)         rdata = base;
      else if (hit_size)         rdata = size;
    end
  end
endmodule

// File: rtl/irqc_status.sv
module irqc_status
  import irqc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] src_set,
  input  logic [N_SRC-1:0] stat_clr,
  input  logic [N_SRC-1:0] en_set,
  input  logic [N_SRC-1:0] en_clr,
  output logic [N_SRC-1:0] stat_q,
  output logic [N_SRC-1:0] en_q,
  output logic             irq_q
);
  logic [N_SRC-1:0] stat_d;
  logic [N_SRC-1:0] en_d;
  logic             irq_d;
  logic             en_ce;

  for (genvar i = 0; i < N_SRC; i++) begin : g_bit
    // a new set beats an acknowledge in the same cycle
    assign stat_d[i] = (stat_q[i] & ~stat_clr[i]) | src_set[i];
    assign en_d[i]   = (en_q[i] | en_set[i]) & ~en_clr[i];
  end

  always_comb begin
    en_ce = |{en_set, en_clr};
    irq_d = |(stat_q & en_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q <= '0;
      en_q   <= '0;
      irq_q  <= 1'b0;
    end else begin
      stat_q <= stat_d;
      if (en_ce) en_q <= en_d;
      irq_q  <= irq_d;
    end
  end
endmodule

// File: rtl/irqc_pool.sv
module irqc_pool #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] wdata,
  input  logic              base_we,
  input  logic              size_we,
  input  logic              pool_empty,
  output logic [DATA_W-1:0] base_q,
  output logic [DATA_W-1:0] size_q,
  output logic              oom_q
);
  logic oom_d;

  always_comb begin
    if (pool_empty)   oom_d = 1'b1;
    else if (size_we) oom_d = 1'b0;
    else              oom_d = oom_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      size_q <= '0;
      oom_q  <= 1'b1;
    end else begin
      if (base_we) base_q <= wdata;
      if (size_we) size_q <= wdata;
      oom_q <= oom_d;
    end
  end
endmodule

// File: rtl/irqc_top.sv
module irqc_top
  import irqc_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  input  logic              flush_done,
  input  logic              render_done,
  input  logic              pool_empty,
  output logic              irq
);
  logic             rst_i_n;
  logic [N_SRC-1:0] stat_q, en_q;
  logic [N_SRC-1:0] stat_clr, en_set, en_clr, src_set;
  logic             base_we, size_we, oom_q;
  logic [DATA_W-1:0] base_q, size_q;

  irqc_rstsync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_i_n)
  );

  irqc_regif #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regif (
    .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wdata(wdata),
    .stat(stat_q), .en(en_q), .base(base_q), .size(size_q),
    .stat_clr(stat_clr), .en_set(en_set), .en_clr(en_clr),
    .base_we(base_we), .size_we(size_we), .rdata(rdata)
  );

  irqc_pool #(.DATA_W(DATA_W)) u_pool (
    .clk(clk), .rst_n(rst_i_n), .wdata(wdata),
    .base_we(base_we), .size_we(size_we), .pool_empty(pool_empty),
    .base_q(base_q), .size_q(size_q), .oom_q(oom_q)
  );

  always_comb begin
    src_set             = '0;
    src_set[SRC_FLUSH]  = flush_done;
    src_set[SRC_RENDER] = render_done;
    src_set[SRC_OOM]    = oom_q;
  end

  irqc_status u_status (
    .clk(clk), .rst_n(rst_i_n), .src_set(src_set),
    .stat_clr(stat_clr), .en_set(en_set), .en_clr(en_clr),
    .stat_q(stat_q), .en_q(en_q), .irq_q(irq)
  );
endmodule

// File: rtl/irqc_chk.sv
module irqc_chk #(
  parameter int ADDR_W = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [ADDR_W-1:0] addr,
  input logic [2:0]        wdata,
  input logic              flush_done,
  input logic              render_done,
  input logic              pool_empty,
  input logic [2:0]        stat,
  input logic [2:0]        en,
  input logic              oom,
  input logic              irq
);
  // R2
  stat_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == ADDR_W'(0) && wdata[0] && !flush_done) |=> !stat[0]);

  // R3
  evt_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == ADDR_W'(0) && wdata[1] && render_done) |=> stat[1]);

  // R4
  en_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == ADDR_W'(4) && wdata[0]) |=> en[0]);

  // R5
  en_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == ADDR_W'(8) && wdata[2]) |=> !en[2]);

  // R7
  oom_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    oom |=> stat[2]);

  // R8
  pool_rel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == ADDR_W'(16) && !pool_empty) |=> !oom);

  // R9
  irq_lag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (irq == $past(|(stat & en))));
endmodule

bind irqc_top irqc_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_i_n), .wr_en(wr_en), .addr(addr),
  .wdata(wdata[2:0]), .flush_done(flush_done), .render_done(render_done),
  .pool_empty(pool_empty), .stat(stat_q), .en(en_q), .oom(oom_q), .irq(irq)
);

// File: tb/tb_irqc_top.sv
module tb_irqc_top;
  localparam int PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [4:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        flush_done = 1'b0, render_done = 1'b0, pool_empty = 1'b0;
  logic        irq;

  int checks = 0;
  int errors = 0;
  int wd = 0;

  // behavioural model state
  int          cnt = 0;
  logic [2:0]  m_stat = '0, m_en = '0;
  logic [31:0] m_base = '0, m_size = '0;
  logic        m_cond = 1'b1, m_irq = 1'b0;

  always #(PERIOD/2) clk = ~clk;

  irqc_top dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .flush_done(flush_done),
    .render_done(render_done), .pool_empty(pool_empty), .irq(irq)
  );

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] mread(input logic [4:0] a);
    case (a)
      5'd0:        return {29'd0, m_stat};
      5'd4, 5'd8:  return {29'd0, m_en};
      5'd12:       return m_base;
      5'd16:       return m_size;
      default:     return 32'd0;
    endcase
  endfunction

  function automatic string tag_of(input logic [4:0] a);
    case (a)
      5'd0:         return "R2";
      5'd4, 5'd8:   return "R6";
      5'd12, 5'd16: return "R8";
      default:      return "R10";
    endcase
  endfunction

  // model: two synchronizer edges after release, logic runs from the third
  always @(posedge clk) begin
    logic [2:0] clr;
    logic       nirq;
    if (!rst_n) cnt = 0; else cnt++;
    if (!rst_n || cnt <= 2) begin
      m_stat = '0; m_en = '0; m_base = '0; m_size = '0;
      m_cond = 1'b1; m_irq = 1'b0;
    end else begin
      clr  = (wr_en && addr == 5'd0) ? wdata[2:0] : 3'd0;
      nirq = |(m_stat & m_en);
      m_stat = (m_stat & ~clr) | {m_cond, render_done, flush_done};
      if (wr_en && addr == 5'd4)  m_en = m_en | wdata[2:0];
      if (wr_en && addr == 5'd8)  m_en = m_en & ~wdata[2:0];
      if (wr_en && addr == 5'd12) m_base = wdata;
      if (wr_en && addr == 5'd16) m_size = wdata;
      if (pool_empty) m_cond = 1'b1;
      else if (wr_en && addr == 5'd16) m_cond = 1'b0;
      m_irq = nirq;
    end
  end

  // per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    #1;
    chk({31'd0, irq}, {31'd0, m_irq}, "R9");
    if (rd_en) chk(rdata, mread(addr), tag_of(addr));
  end

  always @(posedge clk) begin
    wd++;
    if (wd > 20000) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic drv(input logic w, input logic r, input logic [4:0] a,
                     input logic [31:0] d, input logic f, input logic rn,
                     input logic pe);
    @(negedge clk);
    wr_en = w; rd_en = r; addr = a; wdata = d;
    flush_done = f; render_done = rn; pool_empty = pe;
  endtask

  task automatic idle();
    drv(1'b0, 1'b0, 5'd0, 32'd0, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    drv(1'b1, 1'b0, a, d, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic rdchk(input logic [4:0] a, input logic [31:0] exp, input string tag);
    drv(1'b0, 1'b1, a, 32'd0, 1'b0, 1'b0, 1'b0);
    #1;
    chk(rdata, exp, tag);
  endtask

  initial begin
    repeat (2) @(negedge clk);
    // R1: everything reads zero while reset is held
    rdchk(5'd0,  32'd0, "R1");
    rdchk(5'd4,  32'd0, "R1");
    rdchk(5'd12, 32'd0, "R1");
    rdchk(5'd16, 32'd0, "R1");
    chk({31'd0, irq}, 32'd0, "R1");
    @(negedge clk); rst_n = 1'b1;
    repeat (4) idle();
    // R7: out of memory pending from reset
    rdchk(5'd0, 32'd4, "R7");
    // R4 / R6
    wr(5'd4, 32'd3);
    wr(5'd4, 32'd0);
    rdchk(5'd8, 32'd3, "R6");
    rdchk(5'd4, 32'd3, "R4");
    // flush event and irq
    drv(1'b0, 1'b0, 5'd0, 32'd0, 1'b1, 1'b0, 1'b0);
    idle();
    rdchk(5'd0, 32'd5, "R2");
    chk({31'd0, irq}, 32'd1, "R9");
    // R2: clear flush bit
    wr(5'd0, 32'd1);
    idle();
    rdchk(5'd0, 32'd4, "R2");
    chk({31'd0, irq}, 32'd0, "R9");
    // render event, zero write has no effect
    drv(1'b0, 1'b0, 5'd0, 32'd0, 1'b0, 1'b1, 1'b0);
    wr(5'd0, 32'd0);
    rdchk(5'd0, 32'd6, "R2");
    // R3: event with clear in same cycle
    drv(1'b1, 1'b0, 5'd0, 32'd2, 1'b0, 1'b1, 1'b0);
    rdchk(5'd0, 32'd6, "R3");
    wr(5'd0, 32'd2);
    rdchk(5'd0, 32'd4, "R2");
    // R7: clear while condition holds
    wr(5'd0, 32'd4);
    idle();
    rdchk(5'd0, 32'd4, "R7");
    // R8: new pool then clear
    wr(5'd12, 32'h8000_0000);
    wr(5'd16, 32'h0004_0000);
    wr(5'd0, 32'd4);
    rdchk(5'd0, 32'd0, "R8");
    rdchk(5'd12, 32'h8000_0000, "R8");
    rdchk(5'd16, 32'h0004_0000, "R8");
    // R7: pool exhausted again
    drv(1'b0, 1'b0, 5'd0, 32'd0, 1'b0, 1'b0, 1'b1);
    idle();
    rdchk(5'd0, 32'd4, "R7");
    wr(5'd4, 32'd4);
    idle(); idle();
    chk({31'd0, irq}, 32'd1, "R9");
    // R5
    wr(5'd8, 32'd4);
    rdchk(5'd4, 32'd3, "R5");
    wr(5'd8, 32'd0);
    rdchk(5'd8, 32'd3, "R5");
    idle();
    chk({31'd0, irq}, 32'd0, "R5");
    // R8: exhaustion in the same cycle as size write keeps condition
    drv(1'b1, 1'b0, 5'd16, 32'd64, 1'b0, 1'b0, 1'b1);
    wr(5'd0, 32'd4);
    rdchk(5'd0, 32'd4, "R8");
    // R10: unmapped reads
    rdchk(5'd20, 32'd0, "R10");
    rdchk(5'd2,  32'd0, "R10");
    rdchk(5'd31, 32'd0, "R10");
    // randomized traffic compared against the model every clock
    for (int i = 0; i < 600; i++) begin
      int r;
      logic [4:0] a;
      r = int'($urandom % 7);
      a = (r < 5) ? 5'(r * 4) : ((r == 5) ? 5'd20 : 5'd3);
      drv(($urandom % 3) == 0, ($urandom % 2) == 0, a, $urandom,
          ($urandom % 5) == 0, ($urandom % 5) == 0, ($urandom % 9) == 0);
    end
    idle(); idle();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule